// File: doc/BRIEF.md
# UART Interrupt Identification and Status Logic

This block is the interrupt side of a 16550-style serial port. It takes event flags from the receiver (FIFO fill level, overrun, parity error, framing error, break), levels from the transmitter (holding register empty, shifter empty) and the four modem inputs. From these it keeps the line status and modem status registers and holds the interrupt enable mask. It drives one interrupt line and a 3-bit identification code that names the highest-priority source that is both pending and enabled.

Software reaches the block through a small register port with a 3-bit offset, separate read and write strobes, and combinational read data. Reads have side effects. A read of the line status register clears its error flags. A read of the modem status register clears its change flags. A read of the identification register acknowledges a transmit-empty interrupt when that is the code it returns. The same identification offset, when written, sets the receive FIFO trigger level. Serial shifting and FIFO storage sit outside this block.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0x00, the identification register reads 0x01, the line and modem change flags are clear and irq is low.
- R2: Sources are ranked line status (code 0x6) above received data (0x4) above transmit holding empty (0x2) above modem status (0x0). The identification register returns the code of the highest-ranked pending and enabled source in bits 2:0, and bits 7:3 read 0.
- R3: The received-data source is pending when the FIFO fill level is at or above the trigger level. The trigger level is set by bits 7:6 of a write to offset 2: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 (depth/4, depth/2 and depth-2 for other depths).
- R4: Line status bits 1 (overrun), 2 (parity), 3 (framing) and 4 (break) are set by one-cycle event pulses and stay set until the line status register (offset 5) is read. An event that arrives in the same cycle as that read is kept. Any of these bits pending gives the line-status source.
- R5: Line status bit 0 is 1 when the fill level is nonzero, bit 5 follows the holding-empty input, bit 6 follows the shifter-empty input, and bit 7 reads 0.
- R6: Modem status bits 3:0 (bit 0 CTS, 1 DSR, 2 RI, 3 DCD) are set when the matching input changes and are cleared by a read of offset 6. Bits 7:4 show the inputs as registered one clock earlier. Any change flag set gives the modem source.
- R7: The transmit-empty source is set on a rising edge of holding-empty. It is cleared by a read of the identification register that returns 0x2, or when holding-empty falls. An identification read that returns any other code leaves it pending.
- R8: Writing enable bit 1 from 0 to 1 while holding-empty is high arms the transmit-empty source. Rewriting it while it is already 1 does not arm it.
- R9: irq is high exactly when identification bit 0 is 0. Each source takes part only while its enable bit is set: bit 0 received data, bit 1 transmit empty, bit 2 line status, bit 3 modem status.
- R10: Offset 1 reads back the enable register in bits 3:0, with bits 7:4 as 0. Offsets other than 1, 2, 5 and 6 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle; read side effects take place at the clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from addr |
| rx_level | input | LVL_W (5) | Receive FIFO fill count |
| rx_overrun | input | 1 | Overrun event pulse |
| rx_parity_err | input | 1 | Parity error event pulse |
| rx_frame_err | input | 1 | Framing error event pulse |
| rx_break | input | 1 | Break event pulse |
| tx_hold_empty | input | 1 | Transmit holding register empty level |
| tx_shift_empty | input | 1 | Transmitter fully empty level |
| modem_in | input | 4 | Modem inputs: bit 0 CTS, 1 DSR, 2 RI, 3 DCD |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default FIFO depth of 16. With that depth every trigger code reaches its threshold from an exact fill level, so each boundary (3 against 4, 13 against 14, 0 against 1) is tested on both sides. The 4-input modem width lets one step change several inputs at once, so multi-bit change flags are checked together with the registered state nibble. The transmit-empty arming paths (rising edge, 0-to-1 enable write, rewrite with no effect) and the acknowledge rule are checked against higher- and lower-ranked sources pending at the same time.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [2:0] {
        ID_MODEM  = 3'b000,
        ID_NONE   = 3'b001,
        ID_THRE   = 3'b010,
        ID_RXDATA = 3'b100,
        ID_LINE   = 3'b110
    } irq_id_e;

    localparam logic [2:0] OFS_ENABLE = 3'd1;
    localparam logic [2:0] OFS_IDENT  = 3'd2;
    localparam logic [2:0] OFS_LINE   = 3'd5;
    localparam logic [2:0] OFS_MODEM  = 3'd6;

    // one pending flag per source, already masked by its enable bit
    typedef struct packed {
        logic line;
        logic rxd;
        logic thre;
        logic modem;
    } src_t;

endpackage

// File: rtl/uart_irq_line.sv
module uart_irq_line #(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             ev_overrun,
    input  logic             ev_parity,
    input  logic             ev_frame,
    input  logic             ev_break,
    input  logic             hold_empty,
    input  logic             shift_empty,
    input  logic             clr,
    output logic [7:0]       lsr,
    output logic             err_any
);

    typedef struct packed {
        logic [3:0] sticky;
    } line_st_t;

    line_st_t st_d, st_q;
    logic [3:0] events;

    always_comb begin
        events = {ev_break, ev_frame, ev_parity, ev_overrun};
        st_d   = st_q;
        if (clr) begin
            st_d.sticky = 4'b0;
        end
        st_d.sticky = st_d.sticky | events;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lsr     = {1'b0, shift_empty, hold_empty, st_q.sticky, (rx_level != '0)};
    assign err_any = |st_q.sticky;

    // R4: a read with no new event leaves every error flag clear
    p_sticky_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && events == 4'b0) |=> (lsr[4:1] == 4'b0));

    // R4: an event is visible on the next cycle, read or not
    p_sticky_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_overrun |=> lsr[1]);

endmodule

// File: rtl/uart_irq_modem.sv
module uart_irq_modem #(
    parameter int N_IN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   modem_in,
    input  logic              clr,
    output logic [2*N_IN-1:0] msr,
    output logic              chg_any
);

    typedef struct packed {
        logic [N_IN-1:0] state;
        logic [N_IN-1:0] delta;
    } modem_st_t;

    modem_st_t st_d, st_q;
    logic [N_IN-1:0] changed;

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_edge
            assign changed[i] = modem_in[i] ^ st_q.state[i];
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        st_d.state = modem_in;
        if (clr) begin
            st_d.delta = '0;
        end
        st_d.delta = st_d.delta | changed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msr     = {st_q.state, st_q.delta};
    assign chg_any = |st_q.delta;

    // R6: any input change raises a change flag on the next cycle
    p_delta_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (changed != '0) |=> (msr[N_IN-1:0] != '0));

    // R6: state nibble shows the input one clock later
    p_state_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (msr[2*N_IN-1:N_IN] == $past(modem_in)));

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  src_t        pend,
    output irq_id_e     ident,
    output logic        irq
);

    always_comb begin
        if (pend.line) begin
            ident = ID_LINE;
        end else if (pend.rxd) begin
            ident = ID_RXDATA;
        end else if (pend.thre) begin
            ident = ID_THRE;
        end else if (pend.modem) begin
            ident = ID_MODEM;
        end else begin
            ident = ID_NONE;
        end
    end

    assign irq = |pend;

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int N_MODEM    = 4,
    parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_overrun,
    input  logic             rx_parity_err,
    input  logic             rx_frame_err,
    input  logic             rx_break,
    input  logic             tx_hold_empty,
    input  logic             tx_shift_empty,
    input  logic [3:0]       modem_in,
    output logic             irq
);

    localparam logic [LVL_W-1:0] TRIG_0 = LVL_W'(1);
    localparam logic [LVL_W-1:0] TRIG_1 = LVL_W'(FIFO_DEPTH / 4);
    localparam logic [LVL_W-1:0] TRIG_2 = LVL_W'(FIFO_DEPTH / 2);
    localparam logic [LVL_W-1:0] TRIG_3 = LVL_W'(FIFO_DEPTH - 2);

    typedef struct packed {
        logic [3:0] ier;
        logic [1:0] trig;
        logic       thre_pend;
        logic       empty_prev;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [7:0]       lsr;
    logic [7:0]       msr;
    logic             err_any;
    logic             chg_any;
    logic [LVL_W-1:0] trig_lvl;
    logic             rx_hit;
    logic             id_rd, line_rd, modem_rd, ier_wr, fcr_wr;
    logic             empty_rise, rearm;
    src_t             pend;
    irq_id_e          ident;
    logic             prio_irq;

    assign id_rd    = reg_rd && (reg_addr == OFS_IDENT);
    assign line_rd  = reg_rd && (reg_addr == OFS_LINE);
    assign modem_rd = reg_rd && (reg_addr == OFS_MODEM);
    assign ier_wr   = reg_wr && (reg_addr == OFS_ENABLE);
    assign fcr_wr   = reg_wr && (reg_addr == OFS_IDENT);

    uart_irq_line #(.LVL_W(LVL_W)) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_level    (rx_level),
        .ev_overrun  (rx_overrun),
        .ev_parity   (rx_parity_err),
        .ev_frame    (rx_frame_err),
        .ev_break    (rx_break),
        .hold_empty  (tx_hold_empty),
        .shift_empty (tx_shift_empty),
        .clr         (line_rd),
        .lsr         (lsr),
        .err_any     (err_any)
    );

    uart_irq_modem #(.N_IN(N_MODEM)) u_modem (
        .clk      (clk),
        .rst_n    (rst_n),
        .modem_in (modem_in),
        .clr      (modem_rd),
        .msr      (msr),
        .chg_any  (chg_any)
    );

    always_comb begin
        case (ctl_q.trig)
            2'd0:    trig_lvl = TRIG_0;
            2'd1:    trig_lvl = TRIG_1;
            2'd2:    trig_lvl = TRIG_2;
            default: trig_lvl = TRIG_3;
        endcase
        rx_hit = (rx_level >= trig_lvl);
    end

    always_comb begin
        pend.line  = ctl_q.ier[2] && err_any;
        pend.rxd   = ctl_q.ier[0] && rx_hit;
        pend.thre  = ctl_q.ier[1] && ctl_q.thre_pend;
        pend.modem = ctl_q.ier[3] && chg_any;
    end

    uart_irq_prio u_prio (
        .pend  (pend),
        .ident (ident),
        .irq   (prio_irq)
    );

    assign irq = prio_irq;

    always_comb begin
        ctl_d            = ctl_q;
        ctl_d.empty_prev = tx_hold_empty;
        empty_rise       = tx_hold_empty && !ctl_q.empty_prev;
        rearm            = ier_wr && reg_wdata[1] && !ctl_q.ier[1] && tx_hold_empty;

        if (ier_wr) begin
            ctl_d.ier = reg_wdata[3:0];
        end
        if (fcr_wr) begin
            ctl_d.trig = reg_wdata[7:6];
        end

        if (!tx_hold_empty) begin
            ctl_d.thre_pend = 1'b0;
        end else if (empty_rise || rearm) begin
            ctl_d.thre_pend = 1'b1;
        end else if (id_rd && ident == ID_THRE) begin
            ctl_d.thre_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q            <= '0;
            ctl_q.empty_prev <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_ENABLE: reg_rdata = {4'b0, ctl_q.ier};
            OFS_IDENT:  reg_rdata = {5'b0, ident};
            OFS_LINE:   reg_rdata = lsr;
            OFS_MODEM:  reg_rdata = msr;
            default:    reg_rdata = 8'h00;
        endcase
    end

    // R9: the line is low exactly when the code says nothing is pending
    p_irq_matches_id_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (ident != ID_NONE));

    // R9: with every source masked no request is raised
    p_masked_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ier == 4'b0) |-> !irq);

    // R7: an acknowledging read with no fresh edge drops the transmit source
    p_thre_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rd && ident == ID_THRE && !empty_rise && !rearm) |=> !ctl_q.thre_pend);

    // R7: the transmit source never stays set while holding is occupied
    p_thre_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_hold_empty |=> !ctl_q.thre_pend);

    // R2: line status outranks every other source
    p_line_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pend.line |-> (ident == ID_LINE));

endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;

    localparam int LVL_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic             reg_wr = 1'b0;
    logic             reg_rd = 1'b0;
    logic [7:0]       reg_wdata = '0;
    logic [7:0]       reg_rdata;
    logic [LVL_W-1:0] rx_level = '0;
    logic             rx_overrun = 1'b0;
    logic             rx_parity_err = 1'b0;
    logic             rx_frame_err = 1'b0;
    logic             rx_break = 1'b0;
    logic             tx_hold_empty = 1'b1;
    logic             tx_shift_empty = 1'b1;
    logic [3:0]       modem_in = '0;
    logic             irq;

    int checks = 0;
    int errors = 0;
    logic obs = 1'b0;
    logic obs_irq = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    uart_irq_ident uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .reg_addr       (reg_addr),
        .reg_wr         (reg_wr),
        .reg_rd         (reg_rd),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .rx_level       (rx_level),
        .rx_overrun     (rx_overrun),
        .rx_parity_err  (rx_parity_err),
        .rx_frame_err   (rx_frame_err),
        .rx_break       (rx_break),
        .tx_hold_empty  (tx_hold_empty),
        .tx_shift_empty (tx_shift_empty),
        .modem_in       (modem_in),
        .irq            (irq)
    );

    // monitor: samples 2 ns after the falling edge, pops the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (obs) begin
                logic [7:0] got;
                logic [7:0] want;
                string      t;
                want = exp_q.pop_front();
                t    = tag_q.pop_front();
                got  = obs_irq ? {7'b0, irq} : reg_rdata;
                checks++;
                if (got !== want) begin
                    errors++;
                    $display("FAIL %s: got 0x%02h expected 0x%02h", t, got, want);
                end
            end
        end
    end

    task automatic finish_up();
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items never observed", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end");
        finish_up();
    end

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1; obs = 1'b1; obs_irq = 1'b0;
        exp_q.push_back(e); tag_q.push_back(t);
        @(posedge clk); #1;
        reg_rd = 1'b0; obs = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        obs = 1'b1; obs_irq = 1'b1;
        exp_q.push_back({7'b0, e}); tag_q.push_back(t);
        @(posedge clk); #1;
        obs = 1'b0; obs_irq = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic ev(input logic [3:0] m);
        @(negedge clk);
        {rx_break, rx_frame_err, rx_parity_err, rx_overrun} = m;
        @(posedge clk); #1;
        {rx_break, rx_frame_err, rx_parity_err, rx_overrun} = 4'b0;
    endtask

    task automatic set_lvl(input int n);
        @(negedge clk);
        rx_level = LVL_W'(n);
        @(posedge clk); #1;
    endtask

    task automatic set_hold(input logic v);
        @(negedge clk);
        tx_hold_empty = v;
        @(posedge clk); #1;
    endtask

    task automatic set_modem(input logic [3:0] v);
        @(negedge clk);
        modem_in = v;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(3'd1, 8'h00, "R1 enable after reset");
        rd(3'd2, 8'h01, "R1 ident after reset");
        rd(3'd5, 8'h60, "R1 line status after reset");
        rd(3'd6, 8'h00, "R1 modem status after reset");
        chk_irq(1'b0, "R1 irq after reset");

        // R10 unused offsets
        wr(3'd3, 8'hFF);
        wr(3'd7, 8'hFF);
        rd(3'd1, 8'h00, "R10 enable unchanged by unused writes");
        rd(3'd3, 8'h00, "R10 unused offset reads 0");
        wr(3'd1, 8'hFF);
        rd(3'd1, 8'h0F, "R10 enable upper bits read 0");
        wr(3'd1, 8'h00);

        // R3 trigger levels
        wr(3'd2, 8'h40);
        wr(3'd1, 8'h01);
        set_lvl(3);
        rd(3'd2, 8'h01, "R3 level 3 below trigger 4");
        chk_irq(1'b0, "R3 irq low below trigger");
        set_lvl(4);
        rd(3'd2, 8'h04, "R3 level 4 reaches trigger 4");
        chk_irq(1'b1, "R9 irq high with data pending");
        rd(3'd5, 8'h61, "R5 data ready bit");
        wr(3'd2, 8'hC0);
        set_lvl(13);
        rd(3'd2, 8'h01, "R3 level 13 below trigger 14");
        set_lvl(14);
        rd(3'd2, 8'h04, "R3 level 14 reaches trigger 14");
        wr(3'd2, 8'h80);
        set_lvl(7);
        rd(3'd2, 8'h01, "R3 level 7 below trigger 8");
        set_lvl(8);
        rd(3'd2, 8'h04, "R3 level 8 reaches trigger 8");
        wr(3'd2, 8'h00);
        set_lvl(1);
        rd(3'd2, 8'h04, "R3 level 1 reaches trigger 1");
        wr(3'd1, 8'h00);
        rd(3'd2, 8'h01, "R9 received data masked");
        chk_irq(1'b0, "R9 irq low when masked");

        // R4 line status and priority
        wr(3'd1, 8'h05);
        ev(4'b0101);
        rd(3'd2, 8'h06, "R2 line status over received data");
        rd(3'd5, 8'h6B, "R4 overrun and framing set");
        rd(3'd2, 8'h04, "R4 read cleared line source");
        rd(3'd5, 8'h61, "R4 flags cleared after read");
        // event arriving with the read is kept
        @(negedge clk);
        reg_addr = 3'd5; reg_rd = 1'b1; rx_parity_err = 1'b1;
        obs = 1'b1; obs_irq = 1'b0;
        exp_q.push_back(8'h61); tag_q.push_back("R4 read concurrent with parity");
        @(posedge clk); #1;
        reg_rd = 1'b0; rx_parity_err = 1'b0; obs = 1'b0;
        rd(3'd5, 8'h65, "R4 parity kept across read");
        rd(3'd5, 8'h61, "R4 parity cleared by second read");
        ev(4'b1000);
        rd(3'd5, 8'h71, "R4 break flag");
        set_lvl(0);
        @(negedge clk); tx_shift_empty = 1'b0; @(posedge clk); #1;
        rd(3'd5, 8'h20, "R5 shifter busy, no data");
        @(negedge clk); tx_shift_empty = 1'b1; @(posedge clk); #1;

        // R8 re-arm on enable write, R7 acknowledge
        wr(3'd1, 8'h02);
        chk_irq(1'b1, "R8 enable write arms transmit source");
        rd(3'd2, 8'h02, "R8 transmit empty code");
        rd(3'd2, 8'h01, "R7 ident read acknowledged");
        wr(3'd1, 8'h02);
        rd(3'd2, 8'h01, "R8 rewrite of set bit does not arm");
        set_hold(1'b0);
        rd(3'd5, 8'h40, "R5 holding not empty");
        set_hold(1'b1);
        rd(3'd2, 8'h02, "R7 rising edge arms");
        set_hold(1'b0);
        rd(3'd2, 8'h01, "R7 cleared when holding fills");
        set_hold(1'b1);

        // R2 received data over transmit, non-ack read keeps it
        wr(3'd1, 8'h03);
        set_lvl(2);
        rd(3'd2, 8'h04, "R2 received data over transmit empty");
        set_lvl(0);
        rd(3'd2, 8'h02, "R7 transmit source survived other code read");
        rd(3'd2, 8'h01, "R7 acknowledged");

        // R6 modem and R2 transmit over modem
        wr(3'd1, 8'h00);
        wr(3'd1, 8'h0A);
        set_modem(4'b0001);
        rd(3'd2, 8'h02, "R2 transmit empty over modem");
        rd(3'd2, 8'h00, "R2 modem code after ack");
        rd(3'd6, 8'h11, "R6 CTS change and state");
        rd(3'd6, 8'h10, "R6 change flag cleared by read");
        rd(3'd2, 8'h01, "R6 modem source gone");
        chk_irq(1'b0, "R9 irq low when nothing pending");
        set_modem(4'b1010);
        rd(3'd6, 8'hAB, "R6 multi-bit change");
        rd(3'd6, 8'hA0, "R6 cleared, state held");
        wr(3'd1, 8'h02);
        set_modem(4'b0000);
        rd(3'd2, 8'h01, "R9 modem masked");
        rd(3'd6, 8'h0A, "R6 change flags while masked");

        repeat (2) @(posedge clk);
        finish_up();
    end

endmodule